// File: doc/BRIEF.md
# Serial Read-Only Memory Slave

This block is the target side of a four-wire serial memory link: an active-low chip select, a serial clock driven by the host, a serial data input and a serial data output. The only command it carries out is a streaming read. The host lowers chip select and clocks in a 16-bit command frame and then a 16-bit byte address. The block then sends back the addressed byte, followed by each following byte, for as long as chip select stays low.

The storage holds 65536 bytes. Their contents are computed from the address and a seed parameter, so no file and no stored table is needed. The serial pins are oversampled by the block's own clock through two-stage synchronizers. The host must therefore hold each serial clock phase for several system clock cycles.

Top module: `serial_rom_slave`

## Requirements
- R1: While chip select (synchronized) is high, and after reset, `so_oe` is 0 and `so` is 0.
- R2: Input bits are sampled on rising serial clock edges, most significant bit first. The 16-bit command frame, counted from bit 0 (first sent), selects a read only when bits 0-3 are 0, bit 5 is 0, bits 6 and 7 are 1 and bit 15 is 0. Bits 4 and 8-14 are ignored, so both 16'h0300 and 16'h0BFE are reads.
- R3: Frame bits 16 to 31 give the start address, highest address bit first.
- R4: Data bits leave on `so` after falling serial clock edges, starting at the falling edge that closes bit 31. The data MSB is sent first. `so` is stable between falling edges, so the host samples it on the next rising edge, and `so_oe` is 1 during this phase.
- R5: The byte stored at address a equals a[7:0] ^ {a[14:8], a[15]} ^ SEED. The default SEED is 8'h5A.
- R6: After the eighth data bit of a byte, the address advances by one and the next byte follows with no idle bit.
- R7: The address after 16'hFFFF is 16'h0000.
- R8: The serial input has no effect once the address is complete. Toggling it during the data phase leaves the sent bytes unchanged.
- R9: A command frame that does not match R2 is ignored. `so_oe` stays 0 for the rest of that chip select cycle, whatever the serial clock does.
- R10: Raising chip select at any point aborts the transaction and clears the bit counter. The next select starts decoding at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for `so`; 0 means the pin should float |

## Verification
At a byte boundary, one falling serial clock edge does two jobs at once. It sends the least significant bit of the current byte, and it advances the address and loads the next byte into the shifter. If this is wrong, the first bit of the next byte comes out stale or a bit is lost. The bench provokes this by streaming several bytes in one select. It also starts at 16'hFFFE so that the address wrap lands on the same edge. A scoreboard compares every reassembled byte with the computed contents, byte by byte.

// File: rtl/serial_rom_slave.sv
module serial_rom_slave #(
  parameter logic [7:0] SEED = 8'h5A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_oe
);
  localparam int AW = 16;
  localparam int FW = 2 * AW;

  typedef enum logic [1:0] {ST_CMD = 2'd0, ST_ADR = 2'd1, ST_DATA = 2'd2, ST_IGN = 2'd3} st_t;

  logic [1:0] sck_p, cs_p, si_p;
  logic       sck_d;
  st_t        state;
  logic [$clog2(FW)-1:0] bcnt;
  logic [AW-1:0] sh, addr;
  logic [7:0]    dsh;
  logic [2:0]    dcnt;

  wire cs_s      = cs_p[1];
  wire si_s      = si_p[1];
  wire sck_rise  = sck_p[1] & ~sck_d;
  wire sck_fall  = ~sck_p[1] & sck_d;
  wire [AW-1:0] nxt = {sh[AW-2:0], si_s};
  wire cmd_ok    = (nxt[15:12] == 4'd0) && !nxt[10] && (nxt[9:8] == 2'b11) && !nxt[0];
  wire [AW-1:0] addr_inc = addr + 1'b1;

  function automatic logic [7:0] rom_byte(input logic [AW-1:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ SEED;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      sck_d <= 1'b0;
      cs_p  <= 2'b11;
      si_p  <= '0;
    end else begin
      sck_p <= {sck_p[0], sck};
      sck_d <= sck_p[1];
      cs_p  <= {cs_p[0], cs_n};
      si_p  <= {si_p[0], si};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_CMD;
      bcnt  <= '0;
      sh    <= '0;
      addr  <= '0;
      dsh   <= '0;
      dcnt  <= '0;
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else if (cs_s) begin
      state <= ST_CMD;
      bcnt  <= '0;
      dcnt  <= '0;
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else begin
      case (state)
        ST_CMD: if (sck_rise) begin
          sh   <= nxt;
          bcnt <= bcnt + 1'b1;
          if (bcnt == AW - 1)
            state <= cmd_ok ? ST_ADR : ST_IGN;
        end
        ST_ADR: if (sck_rise) begin
          sh   <= nxt;
          bcnt <= bcnt + 1'b1;
          if (bcnt == FW - 1) begin
            state <= ST_DATA;
            addr  <= nxt;
            dsh   <= rom_byte(nxt);
            dcnt  <= '0;
          end
        end
        ST_DATA: if (sck_fall) begin
          so    <= dsh[7];
          so_oe <= 1'b1;
          dcnt  <= dcnt + 1'b1;
          if (dcnt == 3'd7) begin
            addr <= addr_inc;
            dsh  <= rom_byte(addr_inc);
          end else begin
            dsh <= {dsh[6:0], 1'b0};
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module serial_rom_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_s,
  input logic        fall,
  input logic [1:0]  st,
  input logic [4:0]  bcnt,
  input logic [15:0] addr,
  input logic [2:0]  dcnt,
  input logic        so,
  input logic        so_oe
);
  localparam logic [1:0] DATA = 2'd2;
  localparam logic [1:0] IGN  = 2'd3;

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (!so_oe && !so));

  p_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !cs_s) |=> $stable(so));

  p_incr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DATA && fall && dcnt == 3'd7 && !cs_s) |=> (addr == $past(addr) + 16'd1));

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DATA && fall && dcnt == 3'd7 && !cs_s && addr == 16'hFFFF) |=> (addr == 16'h0000));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DATA && !fall && !cs_s) |=> $stable(addr));

  p_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IGN) |-> !so_oe);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (bcnt == 5'd0));
endmodule

bind serial_rom_slave serial_rom_slave_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cs_s  (cs_s),
  .fall  (sck_fall),
  .st    (state),
  .bcnt  (bcnt),
  .addr  (addr),
  .dcnt  (dcnt),
  .so    (so),
  .so_oe (so_oe)
);

// File: tb/tb_serial_rom_slave.sv
module tb_serial_rom_slave;
  localparam int H = 8;
  localparam logic [7:0] SEED = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit mon_en = 1'b0;
  bit watch_en = 1'b0;
  int oe_seen = 0;
  string tag = "R4";
  logic [7:0] expq[$];

  always #2 clk = ~clk;

  serial_rom_slave #(.SEED(SEED)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe)
  );

  function automatic logic [7:0] ref_byte(input logic [15:0] a);
    logic [7:0] hi;
    hi = a[15:8];
    return a[7:0] ^ {hi[6:0], hi[7]} ^ SEED;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b);
    @(negedge clk); si = b;
    wait_clk(H); sck = 1'b1;
    wait_clk(H); sck = 1'b0;
  endtask

  task automatic send16(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) clk_bit(w[i]);
  endtask

  task automatic deselect();
    @(negedge clk); cs_n = 1'b1; mon_en = 1'b0;
    wait_clk(4 * H);
  endtask

  task automatic read_run(input logic [15:0] cmd, input logic [15:0] a, input int n, input bit noisy, input string req);
    tag = req;
    for (int k = 0; k < n; k++) expq.push_back(ref_byte(a + 16'(k)));
    @(negedge clk); cs_n = 1'b0;
    wait_clk(2 * H);
    send16(cmd);
    send16(a);
    mon_en = 1'b1;
    for (int k = 0; k < 8 * n; k++) clk_bit(noisy ? logic'(k % 3 == 1) : 1'b0);
    wait_clk(H);
    check(expq.size() == 0, req, expq.size(), 0);
    deselect();
  endtask

  // monitor: rebuilds bytes from so at rising sck and compares with the scoreboard queue
  initial begin
    logic [7:0] acc;
    int nb;
    nb = 0; acc = '0;
    forever begin
      @(posedge sck);
      if (mon_en) begin
        if (!so_oe) check(1'b0, tag, 0, 1);
        acc = {acc[6:0], so};
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (expq.size() == 0) check(1'b0, tag, acc, -1);
          else begin
            logic [7:0] e;
            e = expq.pop_front();
            check(acc == e, tag, acc, e);
          end
        end
      end else nb = 0;
    end
  end

  always @(posedge clk) if (watch_en && so_oe) oe_seen++;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    check(so_oe == 1'b0, "R1", so_oe, 0);
    check(so == 1'b0, "R1", so, 0);
    rst_n = 1'b1;
    wait_clk(5);
    check(so_oe == 1'b0, "R1", so_oe, 0);

    // R2 R3 R4 R5: single byte, plain command frame
    read_run(16'h0300, 16'h1234, 1, 1'b0, "R5");
    // R2: ignored bits all set to 1
    read_run(16'h0BFE, 16'hA5C3, 2, 1'b0, "R2");
    // R3 R6: streaming across a low-byte boundary
    read_run(16'h0300, 16'h00FE, 5, 1'b0, "R6");
    // R7: wrap on the same edge as the byte change
    read_run(16'h0300, 16'hFFFE, 4, 1'b0, "R7");
    // R8: serial input toggled during data
    read_run(16'h0BFE, 16'h8001, 3, 1'b1, "R8");
    check(so_oe == 1'b0, "R1", so_oe, 0);

    // R9: bad frames stay silent
    for (int v = 0; v < 2; v++) begin
      oe_seen = 0; watch_en = 1'b1;
      @(negedge clk); cs_n = 1'b0;
      wait_clk(2 * H);
      send16(v == 0 ? 16'h0200 : 16'h0301);
      send16(16'h0010);
      for (int k = 0; k < 16; k++) clk_bit(1'b0);
      watch_en = 1'b0;
      check(oe_seen == 0, "R9", oe_seen, 0);
      deselect();
    end

    // R10: abort in the middle of the address, then a clean read
    @(negedge clk); cs_n = 1'b0;
    wait_clk(2 * H);
    send16(16'h0300);
    for (int k = 0; k < 4; k++) clk_bit(1'b1);
    deselect();
    check(so_oe == 1'b0, "R10", so_oe, 0);
    read_run(16'h0300, 16'h0042, 2, 1'b0, "R10");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule